// File: doc/BRIEF.md
# Write-Around First-Level Data Cache with Atomic Invalidate

This block is a small direct-mapped first-level data cache placed between a core request port and a next-level port that leads toward the second-level cache. The core issues loads, stores and compare-and-swap operations, one at a time. A load that finds its line resident is answered from the cache. A load that misses fetches the whole line from the next level, installs it, and answers with the requested word.

The write policy is write-around. Every store goes to the next level, whether or not its line is resident. A store whose line is resident also updates that word in the cache, so later loads hit and see the new value. A store that misses does not allocate a line. A compare-and-swap is always carried out at the next level, which returns the old value and writes the new one only when the compare succeeds. If the target line is resident, the cache invalidates it rather than updating it, so the next load to that line misses and refills. A per-line flag remembers that a line was lost this way. Each miss response reports whether it was caused by such an invalidation.

The core port uses word addresses. The operation codes are 0 for load, 1 for store and 2 for compare-and-swap; code 3 is reserved and is treated as a load. The next-level port carries a single-cycle request pulse, which the next level must accept. The next level later returns a single-cycle response. The next-level operation codes are 0 for a line fetch, 1 for a word write and 2 for compare-and-swap. A fetched line arrives with word k in bits [k*DW +: DW]. The old value of a compare-and-swap, and nothing else, travels in the low DW bits.

Top module: `l1wa_cache`

## Requirements
- R1: After reset every line is invalid, req_ready is 1, and rsp_valid and nl_req_valid are 0. The first load to any address therefore misses.
- R2: A load miss issues exactly one next-level request with op 0, at the line-aligned word address (offset bits zero). Its response carries the requested word from the returned line, with rsp_hit 0, and the line becomes resident.
- R3: A load to a resident line responds in the cycle after acceptance with rsp_hit 1 and the cached word, and issues no next-level request.
- R4: Every store issues exactly one next-level request with op 1, the full word address and the store data. This holds for hits and misses alike. The store's response arrives after the next-level response, with rsp_hit telling whether the line was resident.
- R5: A store to a resident line updates the cached word, so a following load to that word hits and returns the stored data.
- R6: A store that misses does not allocate a line, so a following load to that word misses and returns the stored data from the next level.
- R7: A compare-and-swap issues one next-level request with op 2, the word address, the compare value and the new value. It returns the old value from the low DW bits of the next-level response. Memory changes only when the old value equals the compare value.
- R8: A compare-and-swap whose line is resident answers with rsp_hit 1 and invalidates that line, whether or not the compare succeeds. The next load to that line misses, refills from the next level, and reports rsp_inval_miss 1.
- R9: rsp_inval_miss is 0 for any response that is not a load miss, and 0 for load misses to lines that were never invalidated by compare-and-swap (cold or conflict misses). A refill of that line index clears the flag.
- R10: Only one request is outstanding. req_ready is 0 from the cycle after a miss, store or compare-and-swap is accepted until its response. Each next-level request is a single-cycle pulse.
- R11: The cache is direct-mapped. A load miss to a different tag at the same index replaces the resident line, and the displaced line then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 compare-and-swap, 3 reserved (as load) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data or compare-and-swap new value |
| req_cmp | input | DW | Compare-and-swap compare value |
| rsp_valid | output | 1 | Single-cycle response pulse |
| rsp_rdata | output | DW | Load data or compare-and-swap old value (0 for stores) |
| rsp_hit | output | 1 | Line was resident when the request was accepted |
| rsp_inval_miss | output | 1 | Load miss caused by a compare-and-swap invalidation |
| nl_req_valid | output | 1 | Next-level request pulse |
| nl_req_op | output | 2 | 0 line fetch, 1 word write, 2 compare-and-swap |
| nl_req_addr | output | AW | Word address (line-aligned for fetches) |
| nl_req_wdata | output | DW | Write data or new value |
| nl_req_cmp | output | DW | Compare value |
| nl_rsp_valid | input | 1 | Next-level response pulse |
| nl_rsp_data | input | DW*WORDS_PER_LINE | Fetched line, or old value in low DW bits |

## Verification
The bench targets the asymmetry between stores and compare-and-swap on a resident line. A design that updated the line on compare-and-swap would hit on the following load and never report an invalidation miss. A design that forgot to invalidate after a failed compare would keep serving the line. Stores are checked for next-level forwarding on both hit and miss. A store miss that allocated would turn the following load into a hit, and a store hit that skipped the local update would return stale data. The invalidation flag is probed after a conflict refill of the same index and after a compare-and-swap to a non-resident line. A design that kept the flag too long, or matched it without the tag, would raise a spurious invalidation miss.

// File: rtl/l1wa_pkg.sv
package l1wa_pkg;

    typedef enum logic [1:0] {
        CORE_LOAD  = 2'd0,
        CORE_STORE = 2'd1,
        CORE_CAS   = 2'd2,
        CORE_RSVD  = 2'd3
    } core_op_e;

    typedef enum logic [1:0] {
        NL_FETCH = 2'd0,
        NL_WRITE = 2'd1,
        NL_CAS   = 2'd2,
        NL_NONE  = 2'd3
    } nl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_STORE = 2'd2,
        ST_CAS   = 2'd3
    } ctrl_state_e;

    // Loads and the reserved code share the load path.
    function automatic logic is_load(input core_op_e op);
        return (op == CORE_LOAD) || (op == CORE_RSVD);
    endfunction

endpackage

// File: rtl/l1wa_tags.sv
module l1wa_tags #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_killed,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] killed_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g]  <= 1'b0;
                killed_q[g] <= 1'b0;
                tag_q[g]    <= '0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                valid_q[g]  <= 1'b1;
                killed_q[g] <= 1'b0;
                tag_q[g]    <= fill_tag;
            end else if (inval_en && inval_idx == IDX_W'(g)) begin
                valid_q[g]  <= 1'b0;
                killed_q[g] <= 1'b1;
            end
        end
    end

    logic tag_match;
    always_comb begin
        tag_match = (tag_q[lk_idx] == lk_tag);
        lk_hit    = valid_q[lk_idx] && tag_match;
        lk_killed = !valid_q[lk_idx] && killed_q[lk_idx] && tag_match;
    end

    // R8: an invalidated line is gone on the next cycle
    assert_cas_drops_line_R8: assert property (@(posedge clk) disable iff (rst)
        inval_en |=> !valid_q[$past(inval_idx)]);

    // R2: a refill installs the requested tag
    assert_fill_installs_R2: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));

endmodule

// File: rtl/l1wa_data.sv
module l1wa_data #(
    parameter int DW    = 32,
    parameter int WPL   = 4,
    parameter int LINES = 8,
    parameter int OFF_W = 2,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [DW-1:0]      rd_word,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [DW-1:0]      wr_data,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [DW*WPL-1:0]  fill_line
);

    logic [DW-1:0] words_q [LINES][WPL];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LINES; l++) begin
            for (int w = 0; w < WPL; w++) begin
                if (fill_en && fill_idx == IDX_W'(l)) begin
                    words_q[l][w] <= fill_line[w*DW +: DW];
                end else if (wr_en && wr_idx == IDX_W'(l) && wr_off == OFF_W'(w)) begin
                    words_q[l][w] <= wr_data;
                end
            end
        end
    end

    assign rd_word = words_q[rd_idx][rd_off];

endmodule

// File: rtl/l1wa_ctrl.sv
module l1wa_ctrl
    import l1wa_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 10,
    parameter int OFF_W  = 2,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW-1:0]     req_cmp,
    input  logic              lk_hit,
    input  logic              lk_killed,
    input  logic [DW-1:0]     rd_word,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_hit,
    output logic              rsp_inval_miss,
    output logic              nl_req_valid,
    output logic [1:0]        nl_req_op,
    output logic [AW-1:0]     nl_req_addr,
    output logic [DW-1:0]     nl_req_wdata,
    output logic [DW-1:0]     nl_req_cmp,
    input  logic              nl_rsp_valid,
    input  logic [LINE_W-1:0] nl_rsp_data,
    output logic              wr_en,
    output logic              inval_en,
    output logic              fill_en,
    output logic [AW-1:0]     fill_addr
);

    ctrl_state_e   state_q;
    core_op_e      op;
    nl_op_e        nl_op_q;
    logic          accept;
    logic [AW-1:0] lat_addr_q;
    logic          lat_hit_q;
    logic          lat_killed_q;
    logic [OFF_W-1:0] lat_off;

    assign op        = core_op_e'(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_en     = accept && (op == CORE_STORE) && lk_hit;
    assign inval_en  = accept && (op == CORE_CAS) && lk_hit;
    assign fill_en   = (state_q == ST_FILL) && nl_rsp_valid;
    assign fill_addr = lat_addr_q;
    assign lat_off   = lat_addr_q[OFF_W-1:0];
    assign nl_req_op = nl_op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            nl_req_valid   <= 1'b0;
            nl_op_q        <= NL_NONE;
            nl_req_addr    <= '0;
            nl_req_wdata   <= '0;
            nl_req_cmp     <= '0;
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            rsp_hit        <= 1'b0;
            rsp_inval_miss <= 1'b0;
            lat_addr_q     <= '0;
            lat_hit_q      <= 1'b0;
            lat_killed_q   <= 1'b0;
        end else begin
            nl_req_valid <= 1'b0;
            rsp_valid    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lat_addr_q   <= req_addr;
                        lat_hit_q    <= lk_hit;
                        lat_killed_q <= lk_killed;
                        nl_req_wdata <= req_wdata;
                        nl_req_cmp   <= req_cmp;
                        if (op == CORE_STORE) begin
                            nl_req_valid <= 1'b1;
                            nl_op_q      <= NL_WRITE;
                            nl_req_addr  <= req_addr;
                            state_q      <= ST_STORE;
                        end else if (op == CORE_CAS) begin
                            nl_req_valid <= 1'b1;
                            nl_op_q      <= NL_CAS;
                            nl_req_addr  <= req_addr;
                            state_q      <= ST_CAS;
                        end else if (lk_hit) begin
                            rsp_valid      <= 1'b1;
                            rsp_rdata      <= rd_word;
                            rsp_hit        <= 1'b1;
                            rsp_inval_miss <= 1'b0;
                        end else begin
                            nl_req_valid <= 1'b1;
                            nl_op_q      <= NL_FETCH;
                            nl_req_addr  <= {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
                            state_q      <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (nl_rsp_valid) begin
                        rsp_valid      <= 1'b1;
                        rsp_rdata      <= nl_rsp_data[int'(lat_off)*DW +: DW];
                        rsp_hit        <= 1'b0;
                        rsp_inval_miss <= lat_killed_q;
                        state_q        <= ST_IDLE;
                    end
                end
                ST_STORE: begin
                    if (nl_rsp_valid) begin
                        rsp_valid      <= 1'b1;
                        rsp_rdata      <= '0;
                        rsp_hit        <= lat_hit_q;
                        rsp_inval_miss <= 1'b0;
                        state_q        <= ST_IDLE;
                    end
                end
                ST_CAS: begin
                    if (nl_rsp_valid) begin
                        rsp_valid      <= 1'b1;
                        rsp_rdata      <= nl_rsp_data[DW-1:0];
                        rsp_hit        <= lat_hit_q;
                        rsp_inval_miss <= 1'b0;
                        state_q        <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: each accepted store leaves as a next-level write to the same word
    assert_store_forwarded_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && op == CORE_STORE)
        |=> (nl_req_valid && nl_req_op == NL_WRITE && nl_req_addr == $past(req_addr)));

    // R3: a load hit answers next cycle without next-level traffic
    assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && is_load(op) && lk_hit)
        |=> (!nl_req_valid && rsp_valid && rsp_hit));

    // R2: line fetches are line-aligned
    assert_fetch_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (nl_req_valid && nl_req_op == NL_FETCH) |-> (nl_req_addr[OFF_W-1:0] == '0));

    // R9: an invalidation miss is never reported as a hit
    assert_inval_miss_excl_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_inval_miss) |-> !rsp_hit);

    // R10: next-level requests are single pulses while the core port is held off
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        nl_req_valid |=> (!nl_req_valid && !req_ready));

endmodule

// File: rtl/l1wa_cache.sv
module l1wa_cache #(
    parameter int DW             = 32,
    parameter int AW             = 10,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [AW-1:0]                req_addr,
    input  logic [DW-1:0]                req_wdata,
    input  logic [DW-1:0]                req_cmp,
    output logic                         rsp_valid,
    output logic [DW-1:0]                rsp_rdata,
    output logic                         rsp_hit,
    output logic                         rsp_inval_miss,
    output logic                         nl_req_valid,
    output logic [1:0]                   nl_req_op,
    output logic [AW-1:0]                nl_req_addr,
    output logic [DW-1:0]                nl_req_wdata,
    output logic [DW-1:0]                nl_req_cmp,
    input  logic                         nl_rsp_valid,
    input  logic [DW*WORDS_PER_LINE-1:0] nl_rsp_data
);

    localparam int OFF_W  = $clog2(WORDS_PER_LINE);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = AW - OFF_W - IDX_W;
    localparam int LINE_W = DW * WORDS_PER_LINE;

    logic [OFF_W-1:0] rq_off;
    logic [IDX_W-1:0] rq_idx;
    logic [TAG_W-1:0] rq_tag;
    logic [AW-1:0]    fill_addr;
    logic             lk_hit, lk_killed;
    logic [DW-1:0]    rd_word;
    logic             wr_en, inval_en, fill_en;

    assign rq_off = req_addr[OFF_W-1:0];
    assign rq_idx = req_addr[OFF_W +: IDX_W];
    assign rq_tag = req_addr[AW-1 -: TAG_W];

    l1wa_tags #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (rq_idx),
        .lk_tag    (rq_tag),
        .lk_hit    (lk_hit),
        .lk_killed (lk_killed),
        .fill_en   (fill_en),
        .fill_idx  (fill_addr[OFF_W +: IDX_W]),
        .fill_tag  (fill_addr[AW-1 -: TAG_W]),
        .inval_en  (inval_en),
        .inval_idx (rq_idx)
    );

    l1wa_data #(
        .DW    (DW),
        .WPL   (WORDS_PER_LINE),
        .LINES (LINES),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) u_data (
        .clk       (clk),
        .rd_idx    (rq_idx),
        .rd_off    (rq_off),
        .rd_word   (rd_word),
        .wr_en     (wr_en),
        .wr_idx    (rq_idx),
        .wr_off    (rq_off),
        .wr_data   (req_wdata),
        .fill_en   (fill_en),
        .fill_idx  (fill_addr[OFF_W +: IDX_W]),
        .fill_line (nl_rsp_data)
    );

    l1wa_ctrl #(
        .DW     (DW),
        .AW     (AW),
        .OFF_W  (OFF_W),
        .LINE_W (LINE_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_op         (req_op),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_cmp        (req_cmp),
        .lk_hit         (lk_hit),
        .lk_killed      (lk_killed),
        .rd_word        (rd_word),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_hit        (rsp_hit),
        .rsp_inval_miss (rsp_inval_miss),
        .nl_req_valid   (nl_req_valid),
        .nl_req_op      (nl_req_op),
        .nl_req_addr    (nl_req_addr),
        .nl_req_wdata   (nl_req_wdata),
        .nl_req_cmp     (nl_req_cmp),
        .nl_rsp_valid   (nl_rsp_valid),
        .nl_rsp_data    (nl_rsp_data),
        .wr_en          (wr_en),
        .inval_en       (inval_en),
        .fill_en        (fill_en),
        .fill_addr      (fill_addr)
    );

endmodule

// File: tb/l1wa_cache_bench.sv
module l1wa_cache_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'd0;
    logic [9:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  req_cmp = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         rsp_hit;
    logic         rsp_inval_miss;
    logic         nl_req_valid;
    logic [1:0]   nl_req_op;
    logic [9:0]   nl_req_addr;
    logic [31:0]  nl_req_wdata;
    logic [31:0]  nl_req_cmp;
    logic         nl_rsp_valid = 1'b0;
    logic [127:0] nl_rsp_data = '0;

    always #10 clk = ~clk;

    l1wa_cache u_l1wa_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
        .rsp_inval_miss(rsp_inval_miss),
        .nl_req_valid(nl_req_valid), .nl_req_op(nl_req_op), .nl_req_addr(nl_req_addr),
        .nl_req_wdata(nl_req_wdata), .nl_req_cmp(nl_req_cmp),
        .nl_rsp_valid(nl_rsp_valid), .nl_rsp_data(nl_rsp_data)
    );

    int vectors = 0;
    int misses  = 0;
    logic [31:0] mem [1024];

    int          nl_seen;
    logic [1:0]  nl_last_op;
    logic [9:0]  nl_last_addr;
    logic [31:0] nl_last_wdata, nl_last_cmp;

    logic        got_valid, got_hit, got_im, ready_held;
    logic [31:0] got_data;

    function automatic logic [31:0] seed(input int a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    // Behavioural next level: answers two cycles after a request.
    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = seed(i);
        nl_seen = 0;
        forever begin
            @(negedge clk);
            if (nl_req_valid) begin
                nl_seen++;
                nl_last_op    = nl_req_op;
                nl_last_addr  = nl_req_addr;
                nl_last_wdata = nl_req_wdata;
                nl_last_cmp   = nl_req_cmp;
                repeat (2) @(negedge clk);
                nl_rsp_data = '0;
                case (nl_last_op)
                    2'd0: for (int w = 0; w < 4; w++)
                              nl_rsp_data[w*32 +: 32] = mem[{nl_last_addr[9:2], 2'(w)}];
                    2'd1: mem[nl_last_addr] = nl_last_wdata;
                    default: begin
                        nl_rsp_data[31:0] = mem[nl_last_addr];
                        if (mem[nl_last_addr] == nl_last_cmp) mem[nl_last_addr] = nl_last_wdata;
                    end
                endcase
                nl_rsp_valid = 1'b1;
                @(negedge clk);
                nl_rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [9:0] a,
                          input logic [31:0] wd, input logic [31:0] cm);
        int waitc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nl_seen   = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_cmp = cm;
        @(negedge clk);
        req_valid  = 1'b0;
        ready_held = !req_ready;
        waitc = 0;
        while (!rsp_valid && waitc < 50) begin @(negedge clk); waitc++; end
        got_valid = rsp_valid; got_data = rsp_rdata; got_hit = rsp_hit; got_im = rsp_inval_miss;
    endtask

    task automatic t_reset;
        chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 nl_req_valid after reset", 32'(nl_req_valid), 32'd0);
    endtask

    task automatic t_load_miss_hit;
        do_req(2'd0, 10'h013, 0, 0);
        chk("R1 cold load misses", 32'(got_hit), 32'd0);
        chk("R2 miss data", got_data, seed('h013));
        chk("R2 one fetch", 32'(nl_seen), 32'd1);
        chk("R2 fetch op", 32'(nl_last_op), 32'd0);
        chk("R2 fetch aligned addr", 32'(nl_last_addr), 32'h010);
        chk("R9 cold miss no inval flag", 32'(got_im), 32'd0);
        chk("R10 ready low during miss", 32'(ready_held), 32'd1);
        do_req(2'd0, 10'h012, 0, 0);
        chk("R3 hit flag", 32'(got_hit), 32'd1);
        chk("R3 hit data", got_data, seed('h012));
        chk("R3 no traffic on hit", 32'(nl_seen), 32'd0);
    endtask

    task automatic t_store_hit;
        do_req(2'd1, 10'h011, 32'h1111_2222, 0);
        chk("R4 store hit forwarded", 32'(nl_seen), 32'd1);
        chk("R4 write op", 32'(nl_last_op), 32'd1);
        chk("R4 write addr", 32'(nl_last_addr), 32'h011);
        chk("R4 write data", nl_last_wdata, 32'h1111_2222);
        chk("R4 store hit flag", 32'(got_hit), 32'd1);
        chk("R10 ready low during store", 32'(ready_held), 32'd1);
        do_req(2'd0, 10'h011, 0, 0);
        chk("R5 load after store hit hits", 32'(got_hit), 32'd1);
        chk("R5 updated word", got_data, 32'h1111_2222);
    endtask

    task automatic t_store_miss;
        do_req(2'd1, 10'h045, 32'hBEEF_0045, 0);
        chk("R4 store miss forwarded", 32'(nl_seen), 32'd1);
        chk("R4 store miss flag", 32'(got_hit), 32'd0);
        do_req(2'd0, 10'h045, 0, 0);
        chk("R6 no allocate on store miss", 32'(got_hit), 32'd0);
        chk("R6 data from next level", got_data, 32'hBEEF_0045);
        chk("R9 store miss refill no inval flag", 32'(got_im), 32'd0);
        do_req(2'd0, 10'h044, 0, 0);
        chk("R2 line resident after refill", 32'(got_hit), 32'd1);
    endtask

    task automatic t_cas_hit;
        do_req(2'd2, 10'h012, 32'h5555_AAAA, seed('h012));
        chk("R7 cas op", 32'(nl_last_op), 32'd2);
        chk("R7 cas addr", 32'(nl_last_addr), 32'h012);
        chk("R7 cas cmp", nl_last_cmp, seed('h012));
        chk("R7 cas new", nl_last_wdata, 32'h5555_AAAA);
        chk("R7 cas old value", got_data, seed('h012));
        chk("R8 cas reports resident", 32'(got_hit), 32'd1);
        chk("R9 cas response no inval flag", 32'(got_im), 32'd0);
        do_req(2'd0, 10'h012, 0, 0);
        chk("R8 load after cas misses", 32'(got_hit), 32'd0);
        chk("R8 inval miss flagged", 32'(got_im), 32'd1);
        chk("R8 refilled with swapped value", got_data, 32'h5555_AAAA);
        do_req(2'd0, 10'h013, 0, 0);
        chk("R9 flag cleared after refill (hit)", 32'(got_hit), 32'd1);
        chk("R9 flag cleared after refill", 32'(got_im), 32'd0);
    endtask

    task automatic t_cas_fail;
        do_req(2'd2, 10'h012, 32'h0BAD_0BAD, 32'h1234_5678);
        chk("R7 failed cas old value", got_data, 32'h5555_AAAA);
        chk("R8 failed cas still resident", 32'(got_hit), 32'd1);
        do_req(2'd0, 10'h012, 0, 0);
        chk("R8 failed cas invalidates", 32'(got_im), 32'd1);
        chk("R7 failed cas leaves memory", got_data, 32'h5555_AAAA);
    endtask

    task automatic t_cas_miss;
        do_req(2'd2, 10'h080, 32'h7777_0080, seed('h080));
        chk("R7 cas miss old value", got_data, seed('h080));
        chk("R8 cas miss not resident", 32'(got_hit), 32'd0);
        do_req(2'd0, 10'h080, 0, 0);
        chk("R9 miss after non-resident cas unflagged", 32'(got_im), 32'd0);
        chk("R7 cas miss swapped", got_data, 32'h7777_0080);
    endtask

    task automatic t_conflict;
        do_req(2'd2, 10'h013, 32'h3333_0013, 32'h0);
        chk("R8 cas on resident line", 32'(got_hit), 32'd1);
        do_req(2'd0, 10'h093, 0, 0);
        chk("R11 conflict load misses", 32'(got_hit), 32'd0);
        chk("R9 other tag not flagged", 32'(got_im), 32'd0);
        chk("R11 conflict data", got_data, seed('h093));
        do_req(2'd0, 10'h013, 0, 0);
        chk("R11 displaced line misses", 32'(got_hit), 32'd0);
        chk("R9 flag dropped by conflict refill", 32'(got_im), 32'd0);
        do_req(2'd3, 10'h013, 0, 0);
        chk("R3 reserved op loads and hits", 32'(got_hit), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_load_miss_hit;
        t_store_hit;
        t_store_miss;
        t_cas_hit;
        t_cas_fail;
        t_cas_miss;
        t_conflict;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule